// File: doc/BRIEF.md
# Cache Line Burst Order Generator

This block generates the word address for each data phase of a memory read burst. When `start` is pulsed it captures a start word address, a burst order and a cache line size in words. From the next cycle it shows the first word address with `valid` high. Each cycle in which `advance` is high while `valid` is high completes a data phase, and the address moves to the next word of the chosen order.

Three orders are provided. Linear counts straight up. Toggle and wrap are both critical-word-first orders that stay inside one cache line. Once every word of a line has been issued, the burst moves on to the following line and starts again at the same offset inside it.

A line size other than 4, 8 or 16 words, or the reserved order code, turns the burst into a single-word transfer. In that case `stop_after_first` goes high with the first word, and `valid` drops once that word is accepted.

The controller is a four-state machine:
- `ST_IDLE` is the state after reset and after a single-word transfer ends.
- `ST_LINEAR` is a linear burst.
- `ST_LINE` is a toggle or wrap burst.
- `ST_SINGLE` is a single-word transfer.

Its transitions are:
- **start-ok-linear**: any state to `ST_LINEAR`.
- **start-ok-line**: any state to `ST_LINE`.
- **start-bad**: any state to `ST_SINGLE`.
- **single-done**: `ST_SINGLE` to `ST_IDLE` on `advance`.

Without `start`, `ST_LINEAR` and `ST_LINE` hold their state.

Top module: `burst_order_gen`

## Requirements
- R1: After reset `valid` and `stop_after_first` are 0.
- R2: On the cycle after `start`, `valid` is 1 and `addr` equals the captured `start_addr`. A `start` during a running burst restarts the burst with the new settings.
- R3: Order code 0 (linear) adds one to `addr` on every accepted phase and never wraps at a line boundary.
- R4: Order code 2 (wrap) gives in-line offset (s + k) mod L for the k-th phase of a line, where s is the start offset (`start_addr` mod L) and L is the line size.
- R5: Order code 1 (toggle) gives in-line offset s XOR k for the k-th phase of a line.
- R6: After all L words of a line have been issued in toggle or wrap order, the line base rises by L and the next word is at offset s again.
- R7: With start offset 0, all three orders give the same address sequence.
- R8: A `line_words` value other than 4, 8 or 16 gives a single word. `stop_after_first` is 1 together with that word, and `valid` is 0 after the word is accepted.
- R9: Order code 3 is reserved and behaves as in R8 for any line size.
- R10: `addr` holds while `advance` is low. An `advance` while `valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new burst with the settings below |
| start_addr | input | AW | First word address |
| order_mode | input | 2 | 0 linear, 1 toggle, 2 wrap, 3 reserved |
| line_words | input | MAX_LINE_LOG2+1 | Cache line size in words |
| advance | input | 1 | Current data phase completes this cycle |
| addr | output | AW | Word address of the current phase |
| valid | output | 1 | `addr` is meaningful |
| stop_after_first | output | 1 | Target must end the burst after this first word |

## Verification
Bursts are run with nonzero start offsets at line sizes 4, 8 and 16. They run long enough to cross line boundaries, so the linear order, which must run straight through, is told apart from toggle and wrap, which must go back to the start offset in the next line. A zero start offset is run in all three orders to confirm that they coincide. Stalled `advance` patterns separate holding from stepping. Line sizes 0, 2, 12 and 31, together with the reserved order code, confirm the single-word fallback, and a restart during a burst confirms that a new `start` takes priority.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ORD_LINEAR = 2'd0,
        ORD_TOGGLE = 2'd1,
        ORD_WRAP   = 2'd2,
        ORD_RSVD   = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINEAR,
        ST_LINE,
        ST_SINGLE
    } state_e;
endpackage

// File: rtl/line_size_check.sv
module line_size_check #(
    parameter int MIN_LINE_LOG2 = 2,
    parameter int MAX_LINE_LOG2 = 4,
    localparam int OW  = MAX_LINE_LOG2,
    localparam int LSW = MAX_LINE_LOG2 + 1
) (
    input  logic [LSW-1:0] line_words,
    output logic           size_ok,
    output logic [OW-1:0]  mask
);
    localparam logic [LSW-1:0] MIN_WORDS = LSW'(1) << MIN_LINE_LOG2;

    assign size_ok = $onehot(line_words) && (line_words >= MIN_WORDS);

    // For a power of two, mask bit i is set when a higher bit of the size is set.
    for (genvar i = 0; i < OW; i++) begin : g_mask
        assign mask[i] = |line_words[LSW-1:i+1];
    end
endmodule

// File: rtl/offset_gen.sv
module offset_gen #(
    parameter int OW = 4
) (
    input  logic          use_toggle,
    input  logic [OW-1:0] soff,
    input  logic [OW-1:0] phase,
    input  logic [OW-1:0] mask,
    output logic [OW-1:0] off
);
    logic [OW-1:0] sum;

    always_comb begin
        sum = soff + phase;
        if (use_toggle) off = soff ^ phase;
        else            off = sum & mask;
    end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_pkg::*;
#(
    parameter int AW            = 16,
    parameter int MIN_LINE_LOG2 = 2,
    parameter int MAX_LINE_LOG2 = 4,
    localparam int OW  = MAX_LINE_LOG2,
    localparam int LSW = MAX_LINE_LOG2 + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic [1:0]     order_mode,
    input  logic [LSW-1:0] line_words,
    input  logic           advance,
    output logic [AW-1:0]  addr,
    output logic           valid,
    output logic           stop_after_first
);
    state_e        state, state_nx;
    logic          size_ok, cfg_ok;
    logic [OW-1:0] mask_in, mask_r, soff_r, phase_r, off;
    logic [AW-1:0] lin_r, base_r, mask_in_w, mask_r_w;
    logic          toggle_r;

    line_size_check #(.MIN_LINE_LOG2(MIN_LINE_LOG2), .MAX_LINE_LOG2(MAX_LINE_LOG2)) u_size (
        .line_words (line_words),
        .size_ok    (size_ok),
        .mask       (mask_in)
    );

    offset_gen #(.OW(OW)) u_off (
        .use_toggle (toggle_r),
        .soff       (soff_r),
        .phase      (phase_r),
        .mask       (mask_r),
        .off        (off)
    );

    assign cfg_ok    = size_ok && (order_e'(order_mode) != ORD_RSVD);
    assign mask_in_w = {{(AW-OW){1'b0}}, mask_in};
    assign mask_r_w  = {{(AW-OW){1'b0}}, mask_r};

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start) begin
            if (!cfg_ok)                                    state_nx = ST_SINGLE;
            else if (order_e'(order_mode) == ORD_LINEAR)    state_nx = ST_LINEAR;
            else                                            state_nx = ST_LINE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_LINEAR: state_nx = ST_LINEAR;
                ST_LINE:   state_nx = ST_LINE;
                ST_SINGLE: if (advance) state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_r    <= '0;
            base_r   <= '0;
            soff_r   <= '0;
            phase_r  <= '0;
            mask_r   <= '0;
            toggle_r <= 1'b0;
        end else if (start) begin
            lin_r    <= start_addr;
            base_r   <= start_addr & ~mask_in_w;
            soff_r   <= start_addr[OW-1:0] & mask_in;
            phase_r  <= '0;
            mask_r   <= mask_in;
            toggle_r <= (order_e'(order_mode) == ORD_TOGGLE);
        end else if (advance) begin
            if (state == ST_LINEAR) lin_r <= lin_r + 1'b1;
            if (state == ST_LINE) begin
                if (phase_r == mask_r) begin
                    phase_r <= '0;
                    base_r  <= base_r + mask_r_w + 1'b1;
                end else begin
                    phase_r <= phase_r + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        addr             = lin_r;
        valid            = 1'b0;
        stop_after_first = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LINEAR: valid = 1'b1;
            ST_LINE: begin
                valid = 1'b1;
                addr  = base_r | {{(AW-OW){1'b0}}, off};
            end
            ST_SINGLE: begin
                valid            = 1'b1;
                stop_after_first = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && addr == $past(start_addr)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINEAR && advance && !start) |=> (addr == $past(addr) + 1'b1));

    // R8
    single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINGLE && advance && !start) |=> !valid);

    // R8
    stop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_after_first |-> valid);

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !advance && !start) |=> $stable(addr));
endmodule

// File: tb/sim_burst_order_gen.sv
`timescale 1ns/100ps
module sim_burst_order_gen;
    localparam int AW  = 16;
    localparam int LSW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [AW-1:0]  start_addr = '0;
    logic [1:0]     order_mode = '0;
    logic [LSW-1:0] line_words = '0;
    logic           advance = 1'b0;
    logic [AW-1:0]  addr;
    logic           valid;
    logic           stop_after_first;

    int checks = 0;
    int failures = 0;

    logic [AW-1:0] q_addr[$];
    logic          q_stop[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    burst_order_gen u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .start_addr       (start_addr),
        .order_mode       (order_mode),
        .line_words       (line_words),
        .advance          (advance),
        .addr             (addr),
        .valid            (valid),
        .stop_after_first (stop_after_first)
    );

    task automatic check(string tag, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: each accepted phase pops one expected item
    always @(negedge clk) begin
        if (rst_n && valid && advance) begin
            if (q_addr.size() == 0) begin
                check("R10 unexpected phase", 1'b0, addr, 0);
            end else begin
                logic [AW-1:0] ea;
                logic          es;
                string         et;
                ea = q_addr.pop_front();
                es = q_stop.pop_front();
                et = q_tag.pop_front();
                check({et, " addr"}, addr == ea, addr, ea);
                check({et, " stop_after_first"}, stop_after_first == es, stop_after_first, es);
            end
        end
    end

    // Driver: pushes the expected sequence, then drives the burst
    task automatic run_burst(string tag, int sa, int md, int lw, int n, bit stall);
        bit ok;
        bit ph;
        int cnt;
        ok = (lw == 4 || lw == 8 || lw == 16) && (md != 3);
        if (!ok) n = 1;
        for (int k = 0; k < n; k++) begin
            int a;
            if (!ok || md == 0) begin
                a = sa + k;
            end else begin
                int s, p, j, off;
                s   = sa % lw;
                j   = k / lw;
                p   = k % lw;
                off = (md == 1) ? (s ^ p) : ((s + p) % lw);
                a   = (sa - s) + j * lw + off;
            end
            q_addr.push_back(AW'(a));
            q_stop.push_back(!ok);
            q_tag.push_back(k == 0 ? {"R2/", tag} : tag);
        end
        @(posedge clk); #1;
        start      = 1'b1;
        start_addr = AW'(sa);
        order_mode = 2'(md);
        line_words = LSW'(lw);
        advance    = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        cnt = 0;
        ph  = 1'b0;
        while (cnt < n) begin
            advance = !stall || ph;
            ph = ~ph;
            if (advance) cnt++;
            @(posedge clk); #1;
        end
        advance = 1'b0;
        if (!ok) begin
            @(negedge clk);
            check({tag, " valid after single word"}, valid == 1'b0, valid, 0);
        end
    endtask

    initial begin : watchdog
        #(5 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", valid == 1'b0, valid, 0);
        check("R1 stop_after_first", stop_after_first == 1'b0, stop_after_first, 0);
        rst_n = 1'b1;

        // R10: advance while idle has no effect
        @(posedge clk); #1; advance = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 idle valid", valid == 1'b0, valid, 0);
        @(posedge clk); #1; advance = 1'b0;

        // R3: linear crosses a line boundary with no wrap
        run_burst("R3", 16'h0106, 0, 8, 12, 1'b0);
        // R4/R6: wrap across three lines with stalls
        run_burst("R4_R6", 16'h0106, 2, 8, 20, 1'b1);
        // R5/R6: toggle, size 4 and 16
        run_burst("R5_R6", 16'h0233, 1, 4, 10, 1'b0);
        run_burst("R5", 16'h01A5, 1, 16, 20, 1'b1);
        // R7: offset zero, all orders
        run_burst("R7 linear", 16'h0340, 0, 16, 16, 1'b0);
        run_burst("R7 toggle", 16'h0340, 1, 16, 16, 1'b0);
        run_burst("R7 wrap",   16'h0340, 2, 16, 16, 1'b0);
        // R8: unsupported line sizes
        run_burst("R8 size12", 16'h0455, 2, 12, 1, 1'b0);
        run_burst("R8 size2",  16'h0456, 1, 2, 1, 1'b0);
        run_burst("R8 size0",  16'h0457, 0, 0, 1, 1'b0);
        run_burst("R8 size31", 16'h0458, 2, 31, 1, 1'b0);
        // R9: reserved order
        run_burst("R9", 16'h0501, 3, 8, 1, 1'b0);
        // R10: advance after a single word ended stays idle
        @(posedge clk); #1; advance = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 idle after single", valid == 1'b0, valid, 0);
        @(posedge clk); #1; advance = 1'b0;
        // R2 restart: a new start during a running burst
        run_burst("R2 first", 16'h0610, 0, 8, 3, 1'b0);
        run_burst("R2 restart", 16'h0777, 2, 16, 18, 1'b1);

        repeat (2) @(posedge clk);
        check("R2 queue drained", q_addr.size() == 0, q_addr.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule